// File: doc/BRIEF.md
# Strip-Based Pixel Plot Engine

This block plots one pixel into a frame buffer whose memory is organised in 128-bit strips. Software loads a colour, an X coordinate and a Y coordinate into registers through a small register bus, then writes a plot command. The engine takes a private copy of those operands and works out which strip holds the pixel. It fetches that strip from memory, blends the colour into the single pixel field chosen by the selected raster operation, and stores the whole strip back. No other part of the strip changes.

Each 12-bit pixel sits in the low bits of a 16-bit lane, so one strip holds eight pixels. The low three bits of X pick the lane. The remaining X bits, together with Y times the number of strips in one displayed line, give the strip address. Software polls the command register until it reads zero, and only then issues the next plot. The register read port drives zero whenever it is not being read, so several such slaves can share one OR-combined read bus.

Top module: `pixel_plot_engine`

## Requirements
- R1: A plot reads exactly one strip and then writes exactly one strip, both at address LINE_STRIPS*Y + (X >> 3).
- R2: In the written strip, only the low 12 bits of lane X[2:0] (bits 16*L+11 down to 16*L) may differ from the strip that was read. The upper 4 bits of that lane and all other lanes are written back unchanged.
- R3: Command bits [18:16] select the raster operation applied to colour C and old pixel P: 1 gives C, 2 gives C AND P, 3 gives C OR P, 4 gives C XOR P.
- R4: Register offsets are 0 colour (12 bits), 1 X (12 bits), 2 Y (12 bits) and 3 command. A command is accepted only when bits [7:0] equal 2 and the raster code is 1 to 4. Any other command word is ignored and starts no memory access.
- R5: A read of the command register returns a nonzero value while a plot is in progress, and zero when the engine is idle, including after reset.
- R6: A command written while a plot is in progress is dropped and causes no further memory access.
- R7: Colour, X, Y and the raster code are captured when the command is accepted. Register writes made later do not change the plot in progress.
- R8: reg_rdata is zero whenever reg_sel is low or reg_we is high.
- R9: A memory request is held, with stable address and direction, until mem_ack is seen. No request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register bus select |
| reg_we | input | 1 | Register write strobe (read when low) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, zero when not read |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory direction, high for a write |
| mem_addr | output | 24 | Strip address |
| mem_wdata | output | 128 | Strip write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 128 | Strip read data, valid with mem_ack |

## Verification
The bench plots into lane 0 and lane 7, at the far end of a line, and with each raster operation. It compares every written strip bit by bit against the strip that was read, so a mask that is too narrow or a lane index that is off by one shows up as corrupted neighbours or as black pixels. It rewrites the coordinates and colour straight after issuing a command: a design that reads the live registers instead of its captured copy draws at the wrong strip. It also writes a second command while the engine is busy, and a design without the busy guard then issues an extra write. Commands with bad codes must start no memory access, and the status read must stay nonzero through a slow memory acknowledge.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_MODIFY,
        S_WR_REQ,
        S_WR_WAIT
    } seq_e;

    localparam logic [2:0] ROP_COPY = 3'd1;
    localparam logic [2:0] ROP_AND  = 3'd2;
    localparam logic [2:0] ROP_OR   = 3'd3;
    localparam logic [2:0] ROP_XOR  = 3'd4;

    localparam logic [7:0] CMD_PLOT = 8'd2;

    localparam logic [1:0] OFS_COLOR = 2'd0;
    localparam logic [1:0] OFS_X     = 2'd1;
    localparam logic [1:0] OFS_Y     = 2'd2;
    localparam logic [1:0] OFS_CMD   = 2'd3;
endpackage

// File: rtl/pxp_addr.sv
module pxp_addr #(
    parameter int COORD_W     = 12,
    parameter int ADDR_W      = 24,
    parameter int LINE_STRIPS = 80,
    parameter int LANE_BITS   = 3
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    output logic [ADDR_W-1:0]  addr
);
    logic [ADDR_W-1:0] row_base;
    logic [ADDR_W-1:0] col_ofs;

    always_comb begin
        row_base = ADDR_W'(LINE_STRIPS) * ADDR_W'(y);
        col_ofs  = ADDR_W'(x >> LANE_BITS);
        addr     = row_base + col_ofs;
    end
endmodule

// File: rtl/pxp_merge.sv
module pxp_merge
    import pxp_pkg::*;
#(
    parameter int STRIP_W = 128,
    parameter int LANE_W  = 16,
    parameter int COLOR_W = 12,
    localparam int LANES  = STRIP_W / LANE_W,
    localparam int SEL_W  = $clog2(LANES)
) (
    input  logic [STRIP_W-1:0] strip_in,
    input  logic [SEL_W-1:0]   lane_sel,
    input  logic [COLOR_W-1:0] color,
    input  logic [2:0]         rop,
    output logic [STRIP_W-1:0] strip_out
);
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        logic [LANE_W-1:0]  old_lane;
        logic [COLOR_W-1:0] old_pix;
        logic [COLOR_W-1:0] new_pix;

        always_comb begin
            old_lane = strip_in[gi*LANE_W +: LANE_W];
            old_pix  = old_lane[COLOR_W-1:0];
            case (rop)
                ROP_AND: new_pix = color & old_pix;
                ROP_OR:  new_pix = color | old_pix;
                ROP_XOR: new_pix = color ^ old_pix;
                default: new_pix = color;
            endcase
            if (lane_sel == SEL_W'(gi))
                strip_out[gi*LANE_W +: LANE_W] = {old_lane[LANE_W-1:COLOR_W], new_pix};
            else
                strip_out[gi*LANE_W +: LANE_W] = old_lane;
        end
    end
endmodule

// File: rtl/pxp_seq.sv
module pxp_seq
    import pxp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mem_ack,
    output logic busy,
    output logic mem_req,
    output logic mem_we,
    output logic rd_done,
    output logic do_modify
);
    seq_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:    if (start) state_d = S_RD_REQ;
            S_RD_REQ:  state_d = mem_ack ? S_MODIFY : S_RD_WAIT;
            S_RD_WAIT: if (mem_ack) state_d = S_MODIFY;
            S_MODIFY:  state_d = S_WR_REQ;
            S_WR_REQ:  state_d = mem_ack ? S_IDLE : S_WR_WAIT;
            S_WR_WAIT: if (mem_ack) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy      = (state_q != S_IDLE);
        mem_req   = (state_q == S_RD_REQ) || (state_q == S_RD_WAIT) ||
                    (state_q == S_WR_REQ) || (state_q == S_WR_WAIT);
        mem_we    = (state_q == S_WR_REQ) || (state_q == S_WR_WAIT);
        rd_done   = mem_ack && ((state_q == S_RD_REQ) || (state_q == S_RD_WAIT));
        do_modify = (state_q == S_MODIFY);
    end
endmodule

// File: rtl/pixel_plot_engine.sv
module pixel_plot_engine
    import pxp_pkg::*;
#(
    parameter int COORD_W     = 12,
    parameter int COLOR_W     = 12,
    parameter int LANE_W      = 16,
    parameter int STRIP_W     = 128,
    parameter int ADDR_W      = 24,
    parameter int LINE_STRIPS = 80,
    parameter int REG_W       = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [STRIP_W-1:0] mem_wdata,
    input  logic               mem_ack,
    input  logic [STRIP_W-1:0] mem_rdata
);
    localparam int LANES = STRIP_W / LANE_W;
    localparam int SEL_W = $clog2(LANES);

    typedef struct packed {
        logic [COLOR_W-1:0] color;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [COLOR_W-1:0] p_color;
        logic [COORD_W-1:0] p_x;
        logic [COORD_W-1:0] p_y;
        logic [2:0]         p_rop;
        logic [REG_W-1:0]   p_cmd;
        logic [STRIP_W-1:0] strip;
    } regs_t;

    regs_t r_d, r_q;

    logic               busy, rd_done, do_modify, start;
    logic               cmd_ok;
    logic [2:0]         cmd_rop;
    logic [STRIP_W-1:0] merged;

    always_comb begin
        cmd_rop = reg_wdata[18:16];
        cmd_ok  = (reg_wdata[7:0] == CMD_PLOT) &&
                  (cmd_rop >= ROP_COPY) && (cmd_rop <= ROP_XOR);
        start   = reg_sel && reg_we && (reg_addr == OFS_CMD) && !busy && cmd_ok;
    end

    pxp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_ack   (mem_ack),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .rd_done   (rd_done),
        .do_modify (do_modify)
    );

    pxp_addr #(
        .COORD_W     (COORD_W),
        .ADDR_W      (ADDR_W),
        .LINE_STRIPS (LINE_STRIPS),
        .LANE_BITS   (SEL_W)
    ) u_addr (
        .x    (r_q.p_x),
        .y    (r_q.p_y),
        .addr (mem_addr)
    );

    pxp_merge #(
        .STRIP_W (STRIP_W),
        .LANE_W  (LANE_W),
        .COLOR_W (COLOR_W)
    ) u_merge (
        .strip_in  (r_q.strip),
        .lane_sel  (r_q.p_x[SEL_W-1:0]),
        .color     (r_q.p_color),
        .rop       (r_q.p_rop),
        .strip_out (merged)
    );

    always_comb begin
        r_d = r_q;
        if (reg_sel && reg_we) begin
            case (reg_addr)
                OFS_COLOR: r_d.color = reg_wdata[COLOR_W-1:0];
                OFS_X:     r_d.x     = reg_wdata[COORD_W-1:0];
                OFS_Y:     r_d.y     = reg_wdata[COORD_W-1:0];
                default:   ;
            endcase
        end
        if (start) begin
            r_d.p_color = r_q.color;
            r_d.p_x     = r_q.x;
            r_d.p_y     = r_q.y;
            r_d.p_rop   = cmd_rop;
            r_d.p_cmd   = reg_wdata;
        end
        if (rd_done)   r_d.strip = mem_rdata;
        if (do_modify) r_d.strip = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel && !reg_we) begin
            case (reg_addr)
                OFS_COLOR: reg_rdata = REG_W'(r_q.color);
                OFS_X:     reg_rdata = REG_W'(r_q.x);
                OFS_Y:     reg_rdata = REG_W'(r_q.y);
                default:   reg_rdata = busy ? r_q.p_cmd : '0;
            endcase
        end
    end

    assign mem_wdata = r_q.strip;
endmodule

// File: rtl/pxp_checker.sv
module pxp_checker #(
    parameter int ADDR_W  = 24,
    parameter int STRIP_W = 128,
    parameter int REG_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_sel,
    input logic               reg_we,
    input logic [1:0]         reg_addr,
    input logic [REG_W-1:0]   reg_rdata,
    input logic               mem_req,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_ack,
    input logic [STRIP_W-1:0] mem_rdata
);
    logic [ADDR_W-1:0] rd_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       rd_addr_q <= '0;
        else if (mem_req && !mem_we && mem_ack) rd_addr_q <= mem_addr;
    end

    AST_WR_SAME_STRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == rd_addr_q)); // R1

    AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && reg_sel && !reg_we && reg_addr == 2'd3) |-> (reg_rdata != '0)); // R5

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_sel || reg_we) |-> (reg_rdata == '0)); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R9

    logic unused_ok;
    assign unused_ok = ^mem_rdata;
endmodule

bind pixel_plot_engine pxp_checker #(
    .ADDR_W  (ADDR_W),
    .STRIP_W (STRIP_W),
    .REG_W   (REG_W)
) u_pxp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
);

// File: tb/pixel_plot_engine_test.sv
`timescale 1ns/1ps
module pixel_plot_engine_test;
    localparam int LAT = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_sel = 1'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         mem_req, mem_we;
    logic [23:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int rd_count = 0;
    int viol = 0;
    int lat = 0;
    bit pend = 0;
    logic [23:0]  last_waddr = '0;
    logic [23:0]  last_raddr = '0;
    logic [127:0] mem [int];

    always #2 clk = ~clk;

    pixel_plot_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [127:0] init_strip(int a);
        logic [127:0] r;
        for (int i = 0; i < 8; i++)
            r[i*16 +: 16] = {4'hB, 12'((a * 37 + i * 291 + 5) & 12'hFFF)};
        return r;
    endfunction

    function automatic logic [127:0] rdmem(int a);
        return mem.exists(a) ? mem[a] : init_strip(a);
    endfunction

    function automatic logic [11:0] rop_f(int op, logic [11:0] c, logic [11:0] p);
        case (op)
            2: return c & p;
            3: return c | p;
            4: return c ^ p;
            default: return c;
        endcase
    endfunction

    // memory model: acknowledge LAT cycles after a request appears
    always @(negedge clk) begin
        if (pend && !mem_req) viol++;
        if (mem_ack) begin
            mem_ack = 1'b0;
            lat = 0;
        end else if (mem_req && rst_n) begin
            if (lat >= LAT) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[int'(mem_addr)] = mem_wdata;
                    wr_count++;
                    last_waddr = mem_addr;
                end else begin
                    mem_rdata = rdmem(int'(mem_addr));
                    rd_count++;
                    last_raddr = mem_addr;
                end
            end else begin
                lat++;
            end
        end
        pend = mem_req && !mem_ack;
    end

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            reg_read(2'd3, s);
            if (s == 0) return;
        end
    endtask

    task automatic t_reset();
        logic [31:0] s;
        check(mem_req == 1'b0, "R9 idle after reset", 128'(mem_req), 0);
        reg_read(2'd3, s);
        check(s == 0, "R5 status zero after reset", 128'(s), 0);
    endtask

    task automatic t_plot(int x, int y, logic [11:0] c, int op, string tag);
        int a = 80 * y + x / 8;
        int ln = x % 8;
        int w0 = wr_count;
        int r0 = rd_count;
        logic [127:0] old = rdmem(a);
        logic [127:0] exp = old;
        exp[ln*16 +: 12] = rop_f(op, c, old[ln*16 +: 12]);
        reg_write(2'd0, 32'(c));
        reg_write(2'd1, 32'(x));
        reg_write(2'd2, 32'(y));
        reg_write(2'd3, (32'(op) << 16) | 32'd2);
        wait_idle();
        check(wr_count == w0 + 1 && rd_count == r0 + 1, {"R1 one read one write ", tag},
              128'(wr_count - w0), 1);
        check(last_waddr == 24'(a) && last_raddr == 24'(a), {"R1 strip address ", tag},
              128'(last_waddr), 128'(a));
        check(rdmem(a) == exp, {"R2 R3 strip contents ", tag}, rdmem(a), exp);
    endtask

    task automatic t_busy_status();
        logic [31:0] s;
        reg_write(2'd1, 32'd17);
        reg_write(2'd2, 32'd4);
        reg_write(2'd3, 32'h0001_0002);
        reg_read(2'd3, s);
        check(s != 0, "R5 status nonzero while busy", 128'(s), 128'h1_0002);
        wait_idle();
        reg_read(2'd3, s);
        check(s == 0, "R5 status zero when done", 128'(s), 0);
    endtask

    task automatic t_latch();
        int a = 80 * 2 + 10 / 8;
        logic [127:0] exp = rdmem(a);
        exp[2*16 +: 12] = 12'hEA4;
        reg_write(2'd0, 32'hEA4);
        reg_write(2'd1, 32'd10);
        reg_write(2'd2, 32'd2);
        reg_write(2'd3, 32'h0001_0002);
        reg_write(2'd1, 32'd50);
        reg_write(2'd2, 32'd9);
        reg_write(2'd0, 32'h111);
        wait_idle();
        check(last_waddr == 24'(a), "R7 address from captured coordinates",
              128'(last_waddr), 128'(a));
        check(rdmem(a) == exp, "R7 colour from captured value", rdmem(a), exp);
    endtask

    task automatic t_drop_busy();
        int w0;
        int a = 80 * 1 + 20 / 8;
        reg_write(2'd1, 32'd20);
        reg_write(2'd2, 32'd1);
        w0 = wr_count;
        reg_write(2'd3, 32'h0003_0002);
        reg_write(2'd1, 32'd30);
        reg_write(2'd3, 32'h0001_0002);
        wait_idle();
        repeat (40) @(negedge clk);
        check(wr_count == w0 + 1, "R6 command while busy dropped", 128'(wr_count - w0), 1);
        check(last_waddr == 24'(a), "R6 only first plot written", 128'(last_waddr), 128'(a));
    endtask

    task automatic t_unknown();
        logic [31:0] s;
        int w0 = wr_count;
        int r0 = rd_count;
        reg_write(2'd3, 32'h0001_0005);
        reg_write(2'd3, 32'h0000_0002);
        reg_write(2'd3, 32'h0005_0002);
        reg_read(2'd3, s);
        check(s == 0, "R4 bad command leaves engine idle", 128'(s), 0);
        repeat (30) @(negedge clk);
        check(wr_count == w0 && rd_count == r0, "R4 bad command makes no access",
              128'(wr_count - w0 + rd_count - r0), 0);
    endtask

    task automatic t_wire_or();
        reg_write(2'd0, 32'h5A5);
        @(negedge clk);
        reg_sel = 1'b0; reg_addr = 2'd0;
        #1 check(reg_rdata == 0, "R8 unselected read data zero", 128'(reg_rdata), 0);
        reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 32'h5A5;
        #1 check(reg_rdata == 0, "R8 write cycle read data zero", 128'(reg_rdata), 0);
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plot(0, 0, 12'hEA4, 1, "copy lane0");
        t_plot(7, 3, 12'h3C7, 1, "copy lane7");
        t_plot(12, 6, 12'h0F0, 2, "and");
        t_plot(13, 6, 12'h80F, 3, "or");
        t_plot(639, 5, 12'hFFF, 4, "xor far end");
        t_busy_status();
        t_latch();
        t_drop_busy();
        t_unknown();
        t_wire_or();
        check(viol == 0, "R9 request held until ack", 128'(viol), 0);
        finish_run();
    end
endmodule